// File: doc/BRIEF.md
# Scene-Change Accuracy Mode Controller

This block chooses which of three accuracy operating points a video filter should run at, based on how much the filter output varies between frames. Once per frame an upstream stage presents a fixed-point percentage-change metric, derived from the difference between the sums of absolute output values of consecutive frames, together with a one-cycle strobe. The controller compares the metric with a fixed threshold of about 0.01 and classifies the frame as "above" (large variation) or "below" (little variation).

Two run counters track how many consecutive frames have fallen on each side of the threshold. A four-state sequencer (START, LOW, MEDIUM, HIGH) moves to a neighbouring accuracy level only when the run on the relevant side reaches the length set for that transition. If no transition condition is met, the state holds. The 2-bit mode output indexes a stored filter configuration held elsewhere, and a one-cycle pulse flags each change of mode so a downstream manager can start reconfiguring.

Top module: `accuracy_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mode is START (code 0) and mode_changed is 0.
- R2: Mode codes are START=0, LOW=1, MEDIUM=2, HIGH=3. The first strobed frame after reset moves START to MEDIUM whatever the metric is.
- R3: A frame counts as above when the metric, read as an unsigned fraction with METRIC_W fractional bits, is strictly greater than THRESH (default 655, about 0.01 at 16 bits). A metric equal to THRESH counts as below.
- R4: In MEDIUM, the 15th consecutive above frame moves the mode to HIGH.
- R5: In MEDIUM, the 30th consecutive below frame moves the mode to LOW.
- R6: In LOW, the 10th consecutive above frame moves the mode to MEDIUM.
- R7: In HIGH, the 15th consecutive below frame moves the mode to MEDIUM.
- R8: A frame on the opposite side of the threshold restarts the run count, so only unbroken runs trigger a transition.
- R9: Both run counts clear on every mode change. The frame that causes a change does not count toward any run in the new mode.
- R10: The mode and the pulse update only in the cycle after a strobed frame. mode_changed is high for exactly that one cycle when the mode differs from before, and is low at all other times.
- R11: Each change moves between neighbouring levels (LOW and MEDIUM, or MEDIUM and HIGH), and the mode never returns to START except through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe, one per frame, qualifying frame_metric |
| frame_metric | input | METRIC_W | Percentage change of the filter output, unsigned fraction |
| mode | output | 2 | Selected accuracy mode index |
| mode_changed | output | 1 | One-cycle pulse when mode takes a new value |

## Verification
The assertions assume that frame_valid and frame_metric hold defined values from the first reset cycle. They also assume that the metric matters only in cycles where the strobe is high, so the hold and pulse properties are written relative to the strobe of the previous cycle. The stimulus drives the strobe and metric only at falling edges, holds the strobe low during reset, and mixes back-to-back frames with idle gaps of several cycles. Metrics are chosen just above, exactly at and well above or below the threshold, and runs are broken one frame short of each length.

// File: rtl/acm_pkg.sv
// Shared types for the accuracy mode controller.
// Assumes: the code values are decoded by a downstream configuration table.
package acm_pkg;
    typedef enum logic [1:0] {
        ACM_START = 2'd0,
        ACM_LOW   = 2'd1,
        ACM_MED   = 2'd2,
        ACM_HIGH  = 2'd3
    } acm_mode_e;
endpackage

// File: rtl/acm_side_cmp.sv
// Classifies a frame metric against a fixed threshold.
// Assumes: the metric is an unsigned fraction; equality counts as "below".
module acm_side_cmp #(
    parameter int          METRIC_W = 16,
    parameter int unsigned THRESH   = 655
) (
    input  logic [METRIC_W-1:0] metric,
    output logic                above
);
    localparam logic [METRIC_W-1:0] THRESH_V = METRIC_W'(THRESH);

    // Strict comparison: only a metric over the threshold counts as large variation.
    always_comb begin
        above = (metric > THRESH_V);
    end
endmodule

// File: rtl/acm_run_tracker.sv
// Keeps consecutive-frame run counts for each side of the threshold.
// Assumes: clear is high only on a strobed frame that changes the mode.
// The next-count outputs include the current frame so the sequencer can act on it.
module acm_run_tracker #(
    parameter int MAX_RUN = 30,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             above,
    input  logic             clear,
    output logic [CNT_W-1:0] above_run_nx,
    output logic [CNT_W-1:0] below_run_nx
);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_RUN);

    // Index 0 holds the below run, index 1 the above run.
    logic [1:0][CNT_W-1:0] run_q;
    logic [1:0][CNT_W-1:0] run_nx;

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic             hit;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_nx;

        assign hit = (s == 1) ? above : !above;

        // Next count: restart on the other side, otherwise count up to saturation.
        always_comb begin
            if (!hit)
                cnt_nx = '0;
            else if (cnt_q >= MAX_V)
                cnt_nx = cnt_q;
            else
                cnt_nx = cnt_q + CNT_W'(1);
        end

        // Commit the count on each frame, or clear it when the mode changes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (frame_valid)
                cnt_q <= clear ? '0 : cnt_nx;
        end

        assign run_q[s]  = cnt_q;
        assign run_nx[s] = cnt_nx;
    end

    assign below_run_nx = run_nx[0];
    assign above_run_nx = run_nx[1];

    AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q[0] == '0) || (run_q[1] == '0)); // R8

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q[0] <= MAX_V) && (run_q[1] <= MAX_V)); // R8

    AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && clear) |=> (run_q[0] == '0) && (run_q[1] == '0)); // R9
endmodule

// File: rtl/acm_mode_fsm.sv
// Accuracy mode sequencer: START, LOW, MEDIUM, HIGH.
// Assumes: the run inputs already include the current frame.
// Raises clear toward the run tracker on the frame that changes the mode.
module acm_mode_fsm
    import acm_pkg::*;
#(
    parameter int CNT_W        = 5,
    parameter int RUN_MED_HIGH = 15,
    parameter int RUN_MED_LOW  = 30,
    parameter int RUN_LOW_MED  = 10,
    parameter int RUN_HIGH_MED = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic [CNT_W-1:0] above_run,
    input  logic [CNT_W-1:0] below_run,
    output logic             clear,
    output acm_mode_e        mode,
    output logic             mode_changed
);
    localparam logic [CNT_W-1:0] LIM_MH = CNT_W'(RUN_MED_HIGH);
    localparam logic [CNT_W-1:0] LIM_ML = CNT_W'(RUN_MED_LOW);
    localparam logic [CNT_W-1:0] LIM_LM = CNT_W'(RUN_LOW_MED);
    localparam logic [CNT_W-1:0] LIM_HM = CNT_W'(RUN_HIGH_MED);

    acm_mode_e state_q, state_nx;
    logic      changed_q;
    logic      step;

    // Transition rules: a neighbour move once the run for that edge is long enough.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ACM_START: state_nx = ACM_MED;
            ACM_MED: begin
                if (above_run >= LIM_MH)
                    state_nx = ACM_HIGH;
                else if (below_run >= LIM_ML)
                    state_nx = ACM_LOW;
            end
            ACM_LOW:  if (above_run >= LIM_LM) state_nx = ACM_MED;
            ACM_HIGH: if (below_run >= LIM_HM) state_nx = ACM_MED;
            default:  state_nx = ACM_START;
        endcase
    end

    // A step is a strobed frame whose decision differs from the held mode.
    always_comb begin
        step  = frame_valid && (state_nx != state_q);
        clear = step;
    end

    // Hold the mode between frames and register the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ACM_START;
            changed_q <= 1'b0;
        end else begin
            if (frame_valid)
                state_q <= state_nx;
            changed_q <= step;
        end
    end

    assign mode         = state_q;
    assign mode_changed = changed_q;

    AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(state_q) && !changed_q); // R10

    AST_PULSE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        changed_q |-> (state_q != $past(state_q))); // R10

    AST_NO_START_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACM_START) |=> (state_q != ACM_START)); // R11

    AST_NEIGHBOUR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACM_LOW) |=> (state_q != ACM_HIGH)); // R11

    AST_NEIGHBOUR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACM_HIGH) |=> (state_q != ACM_LOW)); // R11

    AST_START_TO_MED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACM_START && frame_valid) |=> (state_q == ACM_MED)); // R2
endmodule

// File: rtl/accuracy_mode_ctrl.sv
// Top: picks an accuracy mode from per-frame change metrics.
// Assumes: at most one frame_valid strobe per frame; metric is valid with it.
module accuracy_mode_ctrl #(
    parameter int          METRIC_W     = 16,
    parameter int unsigned THRESH       = 655,
    parameter int          RUN_MED_HIGH = 15,
    parameter int          RUN_MED_LOW  = 30,
    parameter int          RUN_LOW_MED  = 10,
    parameter int          RUN_HIGH_MED = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [METRIC_W-1:0] frame_metric,
    output logic [1:0]          mode,
    output logic                mode_changed
);
    import acm_pkg::*;

    localparam int MAX_A   = (RUN_MED_HIGH > RUN_LOW_MED) ? RUN_MED_HIGH : RUN_LOW_MED;
    localparam int MAX_B   = (RUN_MED_LOW > RUN_HIGH_MED) ? RUN_MED_LOW : RUN_HIGH_MED;
    localparam int MAX_RUN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    logic             above;
    logic             clear;
    logic [CNT_W-1:0] above_run_nx;
    logic [CNT_W-1:0] below_run_nx;
    acm_mode_e        mode_e;

    acm_side_cmp #(
        .METRIC_W (METRIC_W),
        .THRESH   (THRESH)
    ) u_cmp (
        .metric (frame_metric),
        .above  (above)
    );

    acm_run_tracker #(
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W)
    ) u_runs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .above        (above),
        .clear        (clear),
        .above_run_nx (above_run_nx),
        .below_run_nx (below_run_nx)
    );

    acm_mode_fsm #(
        .CNT_W        (CNT_W),
        .RUN_MED_HIGH (RUN_MED_HIGH),
        .RUN_MED_LOW  (RUN_MED_LOW),
        .RUN_LOW_MED  (RUN_LOW_MED),
        .RUN_HIGH_MED (RUN_HIGH_MED)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .above_run    (above_run_nx),
        .below_run    (below_run_nx),
        .clear        (clear),
        .mode         (mode_e),
        .mode_changed (mode_changed)
    );

    assign mode = mode_e;
endmodule

// File: tb/accuracy_mode_ctrl_bench.sv
module accuracy_mode_ctrl_bench;
    localparam int TH = 655;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_metric = '0;
    logic [1:0]  mode;
    logic        mode_changed;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [1:0] mode;
        logic       chg;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // Bench reference state
    int ref_mode = 0;
    int ref_above = 0;
    int ref_below = 0;
    logic [1:0] last_mode = 2'd0;
    logic saw = 1'b0;

    always #5 clk = ~clk;

    accuracy_mode_ctrl u_accuracy_mode_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .frame_metric (frame_metric),
        .mode         (mode),
        .mode_changed (mode_changed)
    );

    task automatic check(input string tag, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Driver: strobe one frame and push the expected outcome from the requirements.
    task automatic frame(input int m, input string tag);
        int nm;
        bit up;
        frame_valid  = 1'b1;
        frame_metric = 16'(m);
        up = (m > TH);
        nm = ref_mode;
        if (ref_mode == 0) begin
            nm = 2;
        end else begin
            if (up) begin ref_above++; ref_below = 0; end
            else    begin ref_below++; ref_above = 0; end
            case (ref_mode)
                2: if (ref_above >= 15) nm = 3; else if (ref_below >= 30) nm = 1;
                1: if (ref_above >= 10) nm = 2;
                3: if (ref_below >= 15) nm = 2;
                default: ;
            endcase
        end
        if (nm != ref_mode) begin ref_above = 0; ref_below = 0; end
        exp_q.push_back('{mode: 2'(nm), chg: (nm != ref_mode), tag: tag});
        ref_mode = nm;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        frame_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(input int n, input int m, input string tag);
        for (int i = 0; i < n; i++) frame(m, tag);
    endtask

    always @(posedge clk) saw <= frame_valid;

    // Monitor: compare after each strobed frame; check quiet outputs otherwise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (saw) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " mode"}, int'(mode), int'(e.mode));
                    check({e.tag, " mode_changed"}, int'(mode_changed), int'(e.chg));
                    last_mode = e.mode;
                end
            end else begin
                check("R10 idle pulse", int'(mode_changed), 0);
                check("R10 idle hold", int'(mode), int'(last_mode));
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset pulse", int'(mode_changed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset mode", int'(mode), 0);
        idle(3);
        // R2: first frame goes to MEDIUM even with a high metric
        frame(16'hFFFF, "R2 first frame");
        idle(2);
        // R4/R8: broken above run, then a full one
        frames(14, 700, "R8 above 14");
        frame(TH, "R3 equal is below");
        frames(14, 656, "R4 above 14");
        idle(4);
        frame(16'hFFFF, "R4 15th above");
        idle(3);
        // R7/R8 in HIGH
        frames(14, 0, "R8 below 14");
        frame(900, "R8 break");
        frames(14, 100, "R7 below 14");
        frame(TH, "R7 15th below");
        idle(2);
        // R5: 30 below at the threshold value
        frames(29, TH, "R5 below 29");
        idle(5);
        frame(TH, "R5 30th below");
        // R6/R8 in LOW
        frames(9, 5000, "R6 above 9");
        frame(10, "R8 break low");
        frames(9, 5000, "R6 above 9b");
        frame(5000, "R6 10th above");
        // R9: run cleared on change; 14 more above must not reach HIGH
        frames(14, 5000, "R9 cleared run");
        frame(5000, "R9 15th above");
        idle(5);
        check("R11 final mode", int'(mode), 3);
        if (exp_q.size() != 0) check("R10 leftover", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule